// File: doc/BRIEF.md
# GPIO interrupt routing multiplexer

This block picks up to eight pad signals out of a wide bank of already synchronous GPIO inputs and turns each into one interrupt line for a downstream interrupt controller. Every output channel has its own pad-select field, a trigger choice (level, single edge, or both edges) and an optional inverter. Whatever trigger a channel uses, the downstream controller only ever sees an active-high level or a one-clock rising pulse. Falling-edge, level-low and both-edge sensing are therefore converted inside this block.

Software programs the block through a small word-addressed register bus with an address, write data, a write strobe and a combinational read port. One register holds the trigger bits of all channels. Two registers hold the pad selects, four channels each. A fourth register holds a per-channel filter code, which is only stored and read back. Any write to a trigger or select register re-arms the edge history of the channels it touches, so a change of configuration never produces an interrupt by itself.

Top module: `pad_irq_router`

## Requirements
- R1: After reset every register reads zero and all interrupt outputs are low. This means pad 0 and level-high sensing on every channel.
- R2: Register at byte address 0x0 stores bits 0..23 and reads bits 24..31 as zero. Bit n means edge trigger on channel n, bit 8+n means both-edge, and bit 16+n means invert. Registers at 0x4, 0x8 and 0xC store and return all 32 bits.
- R3: An address other than 0x0, 0x4, 0x8 or 0xC reads zero. A write to such an address changes no register.
- R4: Channel n (0..3) takes its pad index from bits [(n%4)*8 +: 8] of register 0x4, and channel n (4..7) from the same bits of register 0x8. Pads that are not selected have no effect on any output.
- R5: In level mode without invert, irqOut[n] equals the selected pad as sampled at the previous clock edge.
- R6: In level mode with the invert bit set, irqOut[n] is the complement of the selected pad, with the same one-cycle latency.
- R7: With the edge bit set and no invert, a 0-to-1 change of the selected pad gives exactly one cycle of irqOut[n] high, one cycle later. A 1-to-0 change gives nothing.
- R8: With the edge and invert bits set, a 1-to-0 change gives a one-cycle pulse and a 0-to-1 change gives nothing.
- R9: With the both-edge bit set, every change of the selected pad gives a one-cycle pulse, whatever the edge and invert bits hold.
- R10: A write to the trigger register, or to a select register, produces no pulse from the reconfiguration itself. An edge-mode channel that the write touches stays low for the two cycles after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| busAddr | input | ADDR_W (4) | Byte address of the register access |
| busWdata | input | DATA_W (32) | Write data |
| busWe | input | 1 | Write strobe, one cycle per write |
| busRdata | output | DATA_W (32) | Read data for busAddr, combinational |
| padIn | input | NUM_PADS (256) | Synchronous pad inputs |
| irqOut | output | NUM_CH (8) | Active-high level or pulse per channel to the downstream controller |

## Verification
The pad-select mux is driven with all-zero and all-one pad vectors, with a vector that sets only the selected pads, and with its complement that sets every pad except the selected ones. Together these separate a correct mux from one that reads a wrong bit or a wrong field. The selects include pad 255 and pad 0 to cover the ends of the range. Edge modes are checked by stepping the selected pad up and down and sampling the two cycles after each step, which separates rising, falling and both-edge behaviour from level behaviour. The reconfiguration cases pick writes that make the newly conditioned input differ from the stored history, so a missing history re-arm would show up as a pulse.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

  // Write strobes from the register file to the channel datapath
  typedef struct packed {
    logic modeWr;   // trigger register written, all channels
    logic selLoWr;  // lower select register written
    logic selHiWr;  // upper select register written
  } cfgStrobe_t;

endpackage

// File: rtl/irq_router_regs.sv
module irq_router_regs
  import irq_router_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int SEL_W  = 8,
  parameter int FILT_W = 4,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [ADDR_W-1:0]         busAddr,
  input  logic [DATA_W-1:0]         busWdata,
  input  logic                      busWe,
  output logic [DATA_W-1:0]         busRdata,
  output cfgStrobe_t                strobe,
  output logic [NUM_CH-1:0]         edgeEn,
  output logic [NUM_CH-1:0]         bothEn,
  output logic [NUM_CH-1:0]         invEn,
  output logic [NUM_CH*SEL_W-1:0]   selFlat
);

  localparam int EDGE_OFS  = 0;
  localparam int BOTH_OFS  = NUM_CH;
  localparam int INV_OFS   = 2 * NUM_CH;
  localparam int MODE_BITS = 3 * NUM_CH;
  localparam int SEL_BITS  = NUM_CH * SEL_W;
  localparam int HALF_SEL  = SEL_BITS / 2;
  localparam int FILT_BITS = NUM_CH * FILT_W;

  localparam logic [ADDR_W-1:0] ADDR_MODE   = ADDR_W'(4'h0);
  localparam logic [ADDR_W-1:0] ADDR_SEL_LO = ADDR_W'(4'h4);
  localparam logic [ADDR_W-1:0] ADDR_SEL_HI = ADDR_W'(4'h8);
  localparam logic [ADDR_W-1:0] ADDR_FILT   = ADDR_W'(4'hC);

  logic [NUM_CH-1:0]    edgeQ, bothQ, invQ;
  logic [SEL_BITS-1:0]  selQ;
  logic [FILT_BITS-1:0] filtQ;
  logic                 filtWr;

  always_comb begin
    strobe.modeWr  = busWe && (busAddr == ADDR_MODE);
    strobe.selLoWr = busWe && (busAddr == ADDR_SEL_LO);
    strobe.selHiWr = busWe && (busAddr == ADDR_SEL_HI);
    filtWr         = busWe && (busAddr == ADDR_FILT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edgeQ <= '0;
      bothQ <= '0;
      invQ  <= '0;
      selQ  <= '0;
      filtQ <= '0;
    end else begin
      if (strobe.modeWr) begin
        edgeQ <= busWdata[EDGE_OFS +: NUM_CH];
        bothQ <= busWdata[BOTH_OFS +: NUM_CH];
        invQ  <= busWdata[INV_OFS  +: NUM_CH];
      end
      if (strobe.selLoWr) selQ[0 +: HALF_SEL]        <= busWdata[HALF_SEL-1:0];
      if (strobe.selHiWr) selQ[HALF_SEL +: HALF_SEL] <= busWdata[HALF_SEL-1:0];
      if (filtWr)         filtQ                      <= busWdata[FILT_BITS-1:0];
    end
  end

  always_comb begin
    busRdata = '0;
    unique case (busAddr)
      ADDR_MODE:   busRdata[MODE_BITS-1:0] = {invQ, bothQ, edgeQ};
      ADDR_SEL_LO: busRdata[HALF_SEL-1:0]  = selQ[0 +: HALF_SEL];
      ADDR_SEL_HI: busRdata[HALF_SEL-1:0]  = selQ[HALF_SEL +: HALF_SEL];
      ADDR_FILT:   busRdata[FILT_BITS-1:0] = filtQ;
      default:     busRdata = '0;
    endcase
  end

  assign edgeEn  = edgeQ;
  assign bothEn  = bothQ;
  assign invEn   = invQ;
  assign selFlat = selQ;

endmodule

// File: rtl/irq_router_trig.sv
module irq_router_trig (
  input  logic clk,
  input  logic rst_n,
  input  logic padBit,
  input  logic edgeEn,
  input  logic bothEn,
  input  logic invEn,
  input  logic clr,
  output logic irqQ
);

  logic cond, isEdge, pulse;
  logic histQ, suppQ;

  // Both-edge overrides the single-edge and invert settings
  always_comb begin
    cond   = bothEn ? padBit : (padBit ^ invEn);
    isEdge = edgeEn | bothEn;
    pulse  = bothEn ? (cond ^ histQ) : (cond & ~histQ);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      histQ <= 1'b0;
      suppQ <= 1'b0;
      irqQ  <= 1'b0;
    end else if (clr) begin
      suppQ <= 1'b1;
      irqQ  <= isEdge ? 1'b0 : cond;
    end else if (suppQ) begin
      suppQ <= 1'b0;
      histQ <= cond;
      irqQ  <= isEdge ? 1'b0 : cond;
    end else begin
      histQ <= cond;
      irqQ  <= isEdge ? pulse : cond;
    end
  end

endmodule

// File: rtl/irq_router_path.sv
module irq_router_path
  import irq_router_pkg::*;
#(
  parameter int NUM_CH   = 8,
  parameter int SEL_W    = 8,
  parameter int NUM_PADS = 256
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_PADS-1:0]     padIn,
  input  cfgStrobe_t              strobe,
  input  logic [NUM_CH-1:0]       edgeEn,
  input  logic [NUM_CH-1:0]       bothEn,
  input  logic [NUM_CH-1:0]       invEn,
  input  logic [NUM_CH*SEL_W-1:0] selFlat,
  output logic [NUM_CH-1:0]       irqOut
);

  localparam int LO_CH     = NUM_CH / 2;
  localparam int SEL_RANGE = 1 << SEL_W;

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    logic [SEL_W-1:0] sel;
    logic             padBit;
    logic             clr;

    assign sel = selFlat[n*SEL_W +: SEL_W];

    if (NUM_PADS >= SEL_RANGE) begin : g_full
      assign padBit = padIn[sel];
    end else begin : g_part
      assign padBit = (int'(sel) < NUM_PADS) ? padIn[sel] : 1'b0;
    end

    if (n < LO_CH) begin : g_lo
      assign clr = strobe.modeWr | strobe.selLoWr;
    end else begin : g_hi
      assign clr = strobe.modeWr | strobe.selHiWr;
    end

    irq_router_trig u_trig (
      .clk    (clk),
      .rst_n  (rst_n),
      .padBit (padBit),
      .edgeEn (edgeEn[n]),
      .bothEn (bothEn[n]),
      .invEn  (invEn[n]),
      .clr    (clr),
      .irqQ   (irqOut[n])
    );
  end

endmodule

// File: rtl/pad_irq_router.sv
module pad_irq_router
  import irq_router_pkg::*;
#(
  parameter int NUM_CH   = 8,
  parameter int NUM_PADS = 256,
  parameter int SEL_W    = 8,
  parameter int FILT_W   = 4,
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              busWe,
  output logic [DATA_W-1:0] busRdata,
  input  logic [NUM_PADS-1:0] padIn,
  output logic [NUM_CH-1:0] irqOut
);

  cfgStrobe_t              strobe;
  logic [NUM_CH-1:0]       edgeEn, bothEn, invEn;
  logic [NUM_CH*SEL_W-1:0] selFlat;

  irq_router_regs #(
    .NUM_CH (NUM_CH),
    .SEL_W  (SEL_W),
    .FILT_W (FILT_W),
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .busWe    (busWe),
    .busRdata (busRdata),
    .strobe   (strobe),
    .edgeEn   (edgeEn),
    .bothEn   (bothEn),
    .invEn    (invEn),
    .selFlat  (selFlat)
  );

  irq_router_path #(
    .NUM_CH   (NUM_CH),
    .SEL_W    (SEL_W),
    .NUM_PADS (NUM_PADS)
  ) u_path (
    .clk     (clk),
    .rst_n   (rst_n),
    .padIn   (padIn),
    .strobe  (strobe),
    .edgeEn  (edgeEn),
    .bothEn  (bothEn),
    .invEn   (invEn),
    .selFlat (selFlat),
    .irqOut  (irqOut)
  );

endmodule

// File: rtl/irq_router_checks.sv
module irq_router_checks #(
  parameter int NUM_CH   = 8,
  parameter int NUM_PADS = 256,
  parameter int SEL_W    = 8,
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 32
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [ADDR_W-1:0]       busAddr,
  input logic                    busWe,
  input logic [DATA_W-1:0]       busRdata,
  input logic [NUM_PADS-1:0]     padIn,
  input logic [NUM_CH-1:0]       irqOut,
  input logic [NUM_CH-1:0]       edgeEn,
  input logic [NUM_CH-1:0]       bothEn,
  input logic [NUM_CH-1:0]       invEn,
  input logic [NUM_CH*SEL_W-1:0] selFlat
);

  localparam logic [ADDR_W-1:0] ADDR_MODE = '0;

  // R3: misaligned addresses are unmapped and read zero
  p_unmapped_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busAddr[1:0] != 2'b00) |-> (busRdata == '0));

  for (genvar n = 0; n < NUM_CH; n++) begin : g_chk
    // R5/R6: level channel output is last cycle's conditioned pad
    p_level_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !(edgeEn[n] | bothEn[n]) |=>
        (irqOut[n] == $past(padIn[selFlat[n*SEL_W +: SEL_W]] ^ invEn[n])));

    // R7: a single-edge pulse never lasts beyond one cycle
    p_rise_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (edgeEn[n] & ~bothEn[n] & irqOut[n]) |=> !irqOut[n]);

    // R10: reprogramming the trigger register silences edge channels
    p_reconfig_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (busWe && (busAddr == ADDR_MODE) && (edgeEn[n] | bothEn[n])) |=> !irqOut[n]);
  end

endmodule

bind pad_irq_router irq_router_checks #(
  .NUM_CH   (NUM_CH),
  .NUM_PADS (NUM_PADS),
  .SEL_W    (SEL_W),
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W)
) u_checks (
  .clk      (clk),
  .rst_n    (rst_n),
  .busAddr  (busAddr),
  .busWe    (busWe),
  .busRdata (busRdata),
  .padIn    (padIn),
  .irqOut   (irqOut),
  .edgeEn   (edgeEn),
  .bothEn   (bothEn),
  .invEn    (invEn),
  .selFlat  (selFlat)
);

// File: tb/tb_pad_irq_router.sv
`timescale 1ns/1ps
module tb_pad_irq_router;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [3:0]   busAddr = '0;
  logic [31:0]  busWdata = '0;
  logic         busWe = 1'b0;
  logic [31:0]  busRdata;
  logic [255:0] padIn = '0;
  logic [7:0]   irqOut;

  int testsRun = 0;
  int testsFailed = 0;
  logic [7:0] selArr [8];
  bit doneFlag = 0;

  always #2.5 clk = ~clk;

  pad_irq_router dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .busWe    (busWe),
    .busRdata (busRdata),
    .padIn    (padIn),
    .irqOut   (irqOut)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    testsRun++;
    if (got !== exp) begin
      testsFailed++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic busWrite(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0; busAddr = '0;
  endtask

  task automatic busRead(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a;
    #1;
    d = busRdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic logic [7:0] levelExp(input logic [255:0] pads, input logic [7:0] inv);
    logic [7:0] e;
    for (int n = 0; n < 8; n++) e[n] = pads[selArr[n]] ^ inv[n];
    return e;
  endfunction

  task automatic checkLevel(input string req, input logic [255:0] pads, input logic [7:0] inv);
    @(negedge clk);
    padIn = pads;
    @(negedge clk);
    check(req, {24'h0, irqOut}, {24'h0, levelExp(pads, inv)});
  endtask

  // Set pad 5 (channel 0) and check channel 0 in the next two cycles
  task automatic stepCh0(input string req, input logic v, input logic e1, input logic e2);
    @(negedge clk);
    padIn[5] = v;
    @(negedge clk);
    check(req, {31'h0, irqOut[0]}, {31'h0, e1});
    @(negedge clk);
    check(req, {31'h0, irqOut[0]}, {31'h0, e2});
  endtask

  task automatic testReset();
    logic [31:0] d;
    check("R1 irqOut", {24'h0, irqOut}, 32'h0);
    busRead(4'h0, d); check("R1 mode", d, 32'h0);
    busRead(4'h4, d); check("R1 selLo", d, 32'h0);
    busRead(4'h8, d); check("R1 selHi", d, 32'h0);
    busRead(4'hC, d); check("R1 filt", d, 32'h0);
  endtask

  task automatic testRegMap();
    logic [31:0] d;
    busWrite(4'h0, 32'hFFFF_FFFF);
    busRead(4'h0, d); check("R2 mode upper byte zero", d, 32'h00FF_FFFF);
    busWrite(4'h0, 32'h0);
    busWrite(4'hC, 32'hA5C3_1E77);
    busRead(4'hC, d); check("R2 filter readback", d, 32'hA5C3_1E77);
    busWrite(4'h4, 32'hFF11_0305);
    busWrite(4'h8, 32'h0001_4080);
    busRead(4'h4, d); check("R2 selLo readback", d, 32'hFF11_0305);
    busRead(4'h8, d); check("R2 selHi readback", d, 32'h0001_4080);
    idle(2);
  endtask

  task automatic testUnmapped();
    logic [31:0] d;
    logic [3:0] bad [4] = '{4'h1, 4'h6, 4'hB, 4'hF};
    for (int i = 0; i < 4; i++) begin
      busWrite(bad[i], 32'hDEAD_BEEF);
      busRead(bad[i], d); check("R3 unmapped reads zero", d, 32'h0);
    end
    busRead(4'h0, d); check("R3 mode untouched", d, 32'h0);
    busRead(4'h4, d); check("R3 selLo untouched", d, 32'hFF11_0305);
    busRead(4'h8, d); check("R3 selHi untouched", d, 32'h0001_4080);
    busRead(4'hC, d); check("R3 filt untouched", d, 32'hA5C3_1E77);
  endtask

  task automatic testLevel(input string req, input logic [7:0] inv);
    logic [255:0] onlySel = '0;
    for (int n = 0; n < 8; n++) onlySel[selArr[n]] = 1'b1;
    checkLevel(req, '0, inv);
    checkLevel(req, '1, inv);
    checkLevel(req, onlySel, inv);
    checkLevel({req, " R4 unselected pads"}, ~onlySel, inv);
    for (int n = 0; n < 8; n++) begin
      logic [255:0] one = '0;
      one[selArr[n]] = 1'b1;
      checkLevel({req, " R4 single pad"}, one, inv);
    end
  endtask

  task automatic testRise();
    busWrite(4'h0, 32'h0000_0001);
    padIn = '0;
    idle(2);
    stepCh0("R7 rise pulse", 1'b1, 1'b1, 1'b0);
    stepCh0("R7 fall silent", 1'b0, 1'b0, 1'b0);
  endtask

  task automatic testFall();
    padIn = '0; padIn[5] = 1'b1;
    busWrite(4'h0, 32'h0001_0001);
    idle(2);
    stepCh0("R8 fall pulse", 1'b0, 1'b1, 1'b0);
    stepCh0("R8 rise silent", 1'b1, 1'b0, 1'b0);
  endtask

  task automatic testBoth();
    padIn = '0;
    busWrite(4'h0, 32'h0001_0101);
    idle(2);
    stepCh0("R9 both rise", 1'b1, 1'b1, 1'b0);
    stepCh0("R9 both fall", 1'b0, 1'b1, 1'b0);
  endtask

  task automatic testReconfig();
    // Mode write flips conditioned input of channel 0 from 0 to 1
    padIn = '0;
    busWrite(4'h0, 32'h0000_0001);
    idle(2);
    busWrite(4'h0, 32'h0001_0001);
    check("R10 mode write quiet", {31'h0, irqOut[0]}, 32'h0);
    @(negedge clk); check("R10 mode write quiet", {31'h0, irqOut[0]}, 32'h0);
    @(negedge clk); check("R10 mode write quiet", {31'h0, irqOut[0]}, 32'h0);
    // Select write moves channel 0 from a low pad to a high pad
    busWrite(4'h0, 32'h0000_0001);
    padIn = '0; padIn[3] = 1'b1;
    idle(2);
    busWrite(4'h4, 32'hFF11_0303);
    check("R10 select write quiet", {31'h0, irqOut[0]}, 32'h0);
    @(negedge clk); check("R10 select write quiet", {31'h0, irqOut[0]}, 32'h0);
    @(negedge clk); check("R10 select write quiet", {31'h0, irqOut[0]}, 32'h0);
  endtask

  initial begin
    selArr = '{8'd5, 8'd3, 8'd17, 8'd255, 8'd128, 8'd64, 8'd1, 8'd0};
    idle(3);
    #1 rst_n = 1'b1;
    idle(1);
    testReset();
    testRegMap();
    testUnmapped();
    testLevel("R5 level high", 8'h00);
    busWrite(4'h0, 32'h00AA_0000);
    idle(2);
    testLevel("R6 level low", 8'hAA);
    busWrite(4'h0, 32'h0);
    testRise();
    testFall();
    testBoth();
    testReconfig();
    doneFlag = 1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!doneFlag) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

endmodule